// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block is the next-address part of a microprogrammed control unit. A control address register selects one word of an internal control store. The word is copied into a control buffer register, and its fields are presented at the ports. From the current address, the word's sequencing fields, the status flags, the instruction register and a single return register, the block then works out which control-store address comes next.

Each microinstruction takes two clocks. In the first clock (fetch) the block reads the store. In the second clock (execute) the fields are valid at the ports and the address register is loaded at the end of that clock. The sequencing code in the microword selects one of four ways to form the next address:
- fall through to the next address;
- a conditional branch to the address field, with the condition picked from the status flags;
- a dispatch built from a fixed high part and the opcode bits of the instruction register;
- a one-level subroutine call, or a return from it.

An interrupt test is written as a conditional branch on the flag that carries the interrupt request. The store is loaded through a plain write port, and that port also works while reset is held.

Top module: `micro_seq`

## Requirements
- R1: While reset is asserted, `car` is 0 and `exec_phase` is 0. Reset takes effect asynchronously. After release, the first microword executed is the one at address 0.
- R2: `exec_phase` alternates every clock: one fetch clock (0), then one execute clock (1).
- R3: Sequencing code 00 loads `car` with `car`+1, modulo 2^8, so 0xFF is followed by 0x00.
- R4: Sequencing code 01 with condition select 0 always loads `car` with the address field.
- R5: Sequencing code 01 with condition select k (1..7) loads the address field when `flags[k-1]` is 1, and `car`+1 otherwise. The other flag bits have no effect.
- R6: Sequencing code 10 loads `car` with {4'h8, `ir[7:4]`}.
- R7: Sequencing code 11 with condition select 0 is a call. It loads `car` with the address field and stores `car`+1 in the return register.
- R8: Sequencing code 11 with a nonzero condition select is a return and loads `car` from the return register. There is one nesting level only, so a later call overwrites the saved address.
- R9: During the execute clock, the outputs show the fields of the word at `car`. The word is laid out as bits [24:23] sequencing code, [22:20] condition select, [19:12] address field and [11:0] control field.
- R10: `car` changes only at the clock edge that ends an execute clock. It holds its value across the fetch edge.
- R11: When `wr_en` is high at a clock edge, `wr_data` is written into the store at `wr_addr`. This also happens while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-store write enable |
| wr_addr | input | 8 | Control-store write address |
| wr_data | input | 25 | Microword to write |
| ir | input | 8 | Instruction register; the opcode is bits [7:4] |
| flags | input | 7 | Status flags tested by condition selects 1..7 |
| car | output | 8 | Control address register |
| exec_phase | output | 1 | High during the execute clock |
| seq_op | output | 2 | Sequencing code of the current microword |
| csel | output | 3 | Condition select of the current microword |
| addr_fld | output | 8 | Address field of the current microword |
| ctrl | output | 12 | Control field of the current microword |

## Verification
The hardest case to reach is a return whose saved address was overwritten by a second call. Reaching it takes a microprogram that calls the same routine from two different places and then executes a return outside any routine. The stimulus loads such a program while reset is held, and walks it with a flag and instruction-register value given per step. Each conditional branch is tried once with only its own flag set and once with every other flag set. The address wrap is reached by reloading the store during a mid-run reset, so that address 0 jumps straight to 0xFF.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int SEQ_W  = 2;
  localparam int CSEL_W = 3;

  typedef enum logic [SEQ_W-1:0] {
    SQ_NEXT   = 2'b00,
    SQ_BRANCH = 2'b01,
    SQ_MAP    = 2'b10,
    SQ_LINK   = 2'b11
  } seq_op_e;
endpackage

// File: rtl/useq_cmem.sv
module useq_cmem #(
  parameter int AW = 8,
  parameter int W  = 25
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/useq_cond.sv
module useq_cond #(
  parameter int CSEL_W = 3,
  parameter int NF     = (1 << CSEL_W) - 1
) (
  input  logic [CSEL_W-1:0] csel,
  input  logic [NF-1:0]     flags,
  output logic              take
);
  localparam int NSRC = NF + 1;

  logic [NSRC-1:0] src;

  // source 0 is the constant-true condition, sources 1..NF are the flags
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      if (g == 0) begin : g_true
        assign src[g] = 1'b1;
      end else begin : g_flag
        assign src[g] = flags[g-1];
      end
    end
  endgenerate

  assign take = src[csel];
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int              AW     = 8,
  parameter int              IRW    = 8,
  parameter int              OPC_W  = 4,
  parameter logic [AW-OPC_W-1:0] MAP_HI = 4'h8
) (
  input  seq_op_e           op,
  input  logic [CSEL_W-1:0] csel,
  input  logic              take,
  input  logic [AW-1:0]     addr_fld,
  input  logic [AW-1:0]     car,
  input  logic [IRW-1:0]    ir,
  input  logic [AW-1:0]     ret_addr,
  output logic [AW-1:0]     nxt,
  output logic              ret_we,
  output logic [AW-1:0]     ret_val
);
  logic [AW-1:0] inc;
  logic [AW-1:0] mapped;

  assign inc     = car + 1'b1;
  assign mapped  = {MAP_HI, ir[IRW-1 -: OPC_W]};
  assign ret_val = inc;

  always_comb begin
    nxt    = inc;
    ret_we = 1'b0;
    unique case (op)
      SQ_NEXT:   nxt = inc;
      SQ_BRANCH: nxt = take ? addr_fld : inc;
      SQ_MAP:    nxt = mapped;
      SQ_LINK: begin
        if (csel == '0) begin
          nxt    = addr_fld;
          ret_we = 1'b1;
        end else begin
          nxt = ret_addr;
        end
      end
      default:   nxt = inc;
    endcase
  end
endmodule

// File: rtl/micro_seq.sv
module micro_seq
  import useq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CW    = 12,
  parameter int IRW   = 8,
  parameter int OPC_W = 4,
  parameter logic [AW-OPC_W-1:0] MAP_HI = 4'h8,
  localparam int NF   = (1 << CSEL_W) - 1,
  localparam int MW   = SEQ_W + CSEL_W + AW + CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [MW-1:0]     wr_data,
  input  logic [IRW-1:0]    ir,
  input  logic [NF-1:0]     flags,
  output logic [AW-1:0]     car,
  output logic              exec_phase,
  output logic [SEQ_W-1:0]  seq_op,
  output logic [CSEL_W-1:0] csel,
  output logic [AW-1:0]     addr_fld,
  output logic [CW-1:0]     ctrl
);
  localparam int CTRL_LO = 0;
  localparam int ADDR_LO = CW;
  localparam int CSEL_LO = CW + AW;
  localparam int SEQ_LO  = CW + AW + CSEL_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  // state registers
  logic [AW-1:0] car_q, car_d;
  logic          ph_q, ph_d;
  logic [MW-1:0] cbr_q, cbr_d;
  logic [AW-1:0] ret_q, ret_d;
  logic          car_en, cbr_en, ret_en;

  logic [MW-1:0] rd_word;
  logic          take;
  logic [AW-1:0] nxt;
  logic          ret_we;
  logic [AW-1:0] ret_val;
  seq_op_e       op_cur;

  useq_cmem #(.AW(AW), .W(MW)) u_cmem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (car_q),
    .rdata (rd_word)
  );

  assign seq_op   = cbr_q[SEQ_LO  +: SEQ_W];
  assign csel     = cbr_q[CSEL_LO +: CSEL_W];
  assign addr_fld = cbr_q[ADDR_LO +: AW];
  assign ctrl     = cbr_q[CTRL_LO +: CW];
  assign op_cur   = seq_op_e'(seq_op);

  useq_cond #(.CSEL_W(CSEL_W), .NF(NF)) u_cond (
    .csel  (csel),
    .flags (flags),
    .take  (take)
  );

  useq_next #(.AW(AW), .IRW(IRW), .OPC_W(OPC_W), .MAP_HI(MAP_HI)) u_next (
    .op       (op_cur),
    .csel     (csel),
    .take     (take),
    .addr_fld (addr_fld),
    .car      (car_q),
    .ir       (ir),
    .ret_addr (ret_q),
    .nxt      (nxt),
    .ret_we   (ret_we),
    .ret_val  (ret_val)
  );

  // next-state and enables
  always_comb begin
    ph_d   = ~ph_q;
    cbr_en = ~ph_q;
    cbr_d  = rd_word;
    car_en = ph_q;
    car_d  = nxt;
    ret_en = ph_q & ret_we;
    ret_d  = ret_val;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ph_q  <= 1'b0;
      car_q <= '0;
      cbr_q <= '0;
      ret_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (car_en) car_q <= car_d;
      if (cbr_en) cbr_q <= cbr_d;
      if (ret_en) ret_q <= ret_d;
    end
  end

  assign car        = car_q;
  assign exec_phase = ph_q;
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
  parameter int AW = 8,
  parameter int IRW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_i_n,
  input logic          exec_phase,
  input logic [AW-1:0] car,
  input logic [1:0]    seq_op,
  input logic [2:0]    csel,
  input logic [AW-1:0] addr_fld,
  input logic [IRW-1:0] ir
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |-> (car == '0 && !exec_phase));

  p_exec_follows_fetch_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    !exec_phase |=> exec_phase);

  p_fetch_follows_exec_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    exec_phase |=> !exec_phase);

  p_next_inc_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (exec_phase && seq_op == 2'b00) |=> car == AW'($past(car) + 1'b1));

  p_branch_always_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (exec_phase && seq_op == 2'b01 && csel == 3'd0) |=> car == $past(addr_fld));

  p_map_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (exec_phase && seq_op == 2'b10) |=> car == {4'h8, $past(ir[IRW-1 -: 4])});

  p_call_target_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (exec_phase && seq_op == 2'b11 && csel == 3'd0) |=> car == $past(addr_fld));

  p_car_hold_fetch_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !exec_phase |=> $stable(car));
endmodule

bind micro_seq useq_chk #(.AW(AW), .IRW(IRW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_i_n    (rst_sync_n),
  .exec_phase (exec_phase),
  .car        (car),
  .seq_op     (seq_op),
  .csel       (csel),
  .addr_fld   (addr_fld),
  .ir         (ir)
);

// File: tb/sim_micro_seq.sv
`timescale 1ns/1ps
module sim_micro_seq;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [24:0] wr_data;
  logic [7:0]  ir;
  logic [6:0]  flags;
  logic [7:0]  car;
  logic        exec_phase;
  logic [1:0]  seq_op;
  logic [2:0]  csel;
  logic [7:0]  addr_fld;
  logic [11:0] ctrl;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 0;

  micro_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ir(ir), .flags(flags), .car(car), .exec_phase(exec_phase), .seq_op(seq_op),
    .csel(csel), .addr_fld(addr_fld), .ctrl(ctrl)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [24:0] mw(input logic [1:0] op, input logic [2:0] cs,
                                     input logic [7:0] a, input logic [11:0] c);
    return {op, cs, a, c};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [24:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Advance to the next execute clock, checking the two-clock rhythm and
  // that car holds across the fetch edge; then apply inputs and check outputs.
  task automatic step(input logic [6:0] f, input logic [7:0] i,
                      input logic [7:0] ecar, input logic [11:0] ectrl, input bit first);
    int n = 0;
    logic [7:0] car_f = car;
    @(negedge clk); n++;
    if (!exec_phase) car_f = car;
    while (!exec_phase && n < 16) begin
      @(negedge clk); n++;
    end
    if (!first) chk(n == 2, "R2 clocks per microinstruction", n, 2);
    chk(car == car_f, "R10 car held across fetch edge", car, car_f);
    flags = f; ir = i;
    chk(car == ecar, "R9 car in execute clock", car, ecar);
    chk(ctrl == ectrl, "R9 ctrl field", ctrl, ectrl);
  endtask

  // {flags, ir, expected car, expected ctrl}
  localparam int NSTEP = 18;
  localparam logic [34:0] TBL [NSTEP] = '{
    {7'h00, 8'h00, 8'h00, 12'h001},  // R3 fall through
    {7'h00, 8'h00, 8'h01, 12'h002},  // R4 branch always
    {7'h7D, 8'h00, 8'h04, 12'h004},  // R5 own flag clear, others set
    {7'h00, 8'h3C, 8'h05, 12'h005},  // R6 map opcode 3
    {7'h00, 8'h00, 8'h83, 12'h083},  // R6 landed, R4 branch to 0
    {7'h00, 8'h00, 8'h00, 12'h001},
    {7'h00, 8'h00, 8'h01, 12'h002},
    {7'h02, 8'h00, 8'h04, 12'h004},  // R5 flag1 set
    {7'h00, 8'h00, 8'h10, 12'h010},  // R7 call 0x20
    {7'h00, 8'h00, 8'h20, 12'h020},  // R8 return
    {7'h00, 8'h00, 8'h11, 12'h011},  // R8 landed at call+1
    {7'h00, 8'hA7, 8'h05, 12'h005},  // R6 map opcode A
    {7'h00, 8'h00, 8'h8A, 12'h08A},  // R7 second call
    {7'h00, 8'h00, 8'h20, 12'h020},  // R8 return
    {7'h3F, 8'h00, 8'h8B, 12'h08B},  // R5 flag6 clear, others set
    {7'h00, 8'h00, 8'h8C, 12'h08C},  // R8 stray return
    {7'h40, 8'h00, 8'h8B, 12'h08B},  // R8 single level: saved 0x8B; R5 flag6 set
    {7'h00, 8'h00, 8'h00, 12'h001}
  };

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ir = '0; flags = '0;
    // R11: program loaded while reset is held
    wr(8'h00, mw(2'b00, 3'd0, 8'h00, 12'h001));
    wr(8'h01, mw(2'b01, 3'd0, 8'h04, 12'h002));
    wr(8'h04, mw(2'b01, 3'd2, 8'h10, 12'h004));
    wr(8'h05, mw(2'b10, 3'd0, 8'h00, 12'h005));
    wr(8'h10, mw(2'b11, 3'd0, 8'h20, 12'h010));
    wr(8'h20, mw(2'b11, 3'd1, 8'h00, 12'h020));
    wr(8'h11, mw(2'b01, 3'd0, 8'h05, 12'h011));
    wr(8'h83, mw(2'b01, 3'd0, 8'h00, 12'h083));
    wr(8'h8A, mw(2'b11, 3'd0, 8'h20, 12'h08A));
    wr(8'h8B, mw(2'b01, 3'd7, 8'h00, 12'h08B));
    wr(8'h8C, mw(2'b11, 3'd1, 8'h00, 12'h08C));
    @(negedge clk);
    chk(car == 8'h00, "R1 car in reset", car, 0);
    chk(exec_phase == 1'b0, "R1 phase in reset", exec_phase, 0);
    rst_n = 1'b1;

    for (int k = 0; k < NSTEP; k++) begin
      step(TBL[k][34:28], TBL[k][27:20], TBL[k][19:12], TBL[k][11:0], k == 0);
      if (k == 2) begin
        // R9: field positions of the word at 0x04
        chk(seq_op == 2'b01, "R9 seq_op field", seq_op, 1);
        chk(csel == 3'd2, "R9 csel field", csel, 2);
        chk(addr_fld == 8'h10, "R9 addr field", addr_fld, 8'h10);
      end
    end

    // R1: asynchronous reset in mid run, then R11 rewrite during reset
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(car == 8'h00, "R1 car after async reset", car, 0);
    chk(exec_phase == 1'b0, "R1 phase after async reset", exec_phase, 0);
    wr(8'h00, mw(2'b01, 3'd0, 8'hFF, 12'h0AA));
    wr(8'hFF, mw(2'b00, 3'd0, 8'h00, 12'hABC));
    flags = '0; ir = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step(7'h00, 8'h00, 8'h00, 12'h0AA, 1'b1);  // R11 rewritten word, R1 start at 0
    step(7'h00, 8'h00, 8'hFF, 12'hABC, 1'b0);  // R4
    step(7'h00, 8'h00, 8'h00, 12'h0AA, 1'b0);  // R3 wrap 0xFF -> 0x00

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule